// File: doc/BRIEF.md
# Write-Once Coherence Line Controller

This block keeps the coherence state of every line of one cache that shares a snooping bus with other caches under a write-once policy. A line is either invalid, valid (clean and possibly shared), reserved (clean and exclusive after exactly one write-through) or dirty (modified and exclusive). The first processor write to a shared clean line goes through to memory and invalidates the other copies. Every later write stays local and marks the line dirty.

The processor side presents one request at a time: a line index, an operation (read, write or evict) and the tag comparison result from the cache's own tag array. It holds the request until the block pulses completion. The block drives one bus command at a time and waits for the bus to acknowledge it. In the same cycle it applies any snooped transaction from another cache to its own copy, and it raises a supply strobe when its copy is dirty and must be written back or forwarded. Data storage, tags, victim choice and arbitration are done elsewhere. A fill into a line whose tag mismatches overwrites that line's state, so the processor side evicts a resident dirty line first.

Top module: `wo_line_ctrl`

## Requirements
- R1: After reset every line reads as invalid on `lookupState`. The state encoding is invalid=0, valid=1, reserved=2, dirty=3.
- R2: A processor read (`cpuOp`=0) hits when `tagHit` is high and the line is not invalid. A hit completes with no bus command. A miss issues a bus read (`busCmd`=1) and installs the line as valid.
- R3: A write (`cpuOp`=1) that hits a valid line issues a write-through (`busCmd`=2). When the bus acknowledges it, the line becomes reserved.
- R4: A snooped write-through (`snpCmd`=2) that matches a local copy sets that copy to invalid.
- R5: A write that hits a reserved or dirty line completes with no bus command and leaves the line dirty.
- R6: A snooped read (`snpCmd`=1) that matches a dirty copy raises `snpSupply` in that cycle and moves the copy to valid.
- R7: A write miss issues a bus read and then a write-through. It ends with the line reserved locally and invalid in every other cache.
- R8: A snooped read that matches a reserved copy moves it to valid without raising `snpSupply`.
- R9: An evict (`cpuOp`=2) of a dirty line issues a write-back (`busCmd`=3) and then sets the line invalid. Evicting a valid or reserved line sets it invalid with no bus command. Evicting an invalid line only completes.
- R10: A snooped invalidate (`snpCmd`=3) that matches a local copy sets it invalid. If the copy was dirty, `snpSupply` is raised in that cycle.
- R11: A snoop that changes the state of the line the processor is working on takes priority. Any local state update for that line in the same cycle is dropped, a pending bus command is withdrawn in the next cycle, and the request is re-evaluated from the new state.
- R12: `cpuDone` is high for exactly one cycle per request. No further request is taken in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cpuReq | input | 1 | Processor request, held until `cpuDone` |
| cpuOp | input | 2 | 0 read, 1 write, 2 evict |
| cpuLine | input | IDX_W | Line index of the request, also the line shown on `lookupState` |
| tagHit | input | 1 | Tag match for `cpuLine` |
| cpuDone | output | 1 | One-cycle completion pulse |
| lookupState | output | 2 | Current state of `cpuLine` |
| busReq | output | 1 | Bus command pending |
| busCmd | output | 2 | 0 none, 1 read, 2 write-through, 3 write-back |
| busLine | output | IDX_W | Line of the pending bus command |
| busAck | input | 1 | Bus carries out the pending command in this cycle |
| snpValid | input | 1 | Snooped transaction from another cache |
| snpCmd | input | 2 | 1 read, 2 write-through, 3 invalidate |
| snpLine | input | IDX_W | Line index of the snooped transaction |
| snpTagHit | input | 1 | Tag match for `snpLine` |
| snpSupply | output | 1 | Local dirty copy must be written back or forwarded |

## Verification
The bound assertions watch the single-line transitions on every cycle: issuing a write-through from valid, local dirty writes, fills ending valid, write-through acknowledgements ending reserved, clean evictions, the supply strobe and the snooped read and invalidate transitions, collision withdrawal and the completion pulse. Only the two-cache scenarios show the protocol as a whole. These include the ordered bus traffic of a write miss, the invalidation of the peer's copy by a write-through, the forwarding of dirty data to a reader, and two caches writing the same shared line at once, where the losing cache drops its write-through and retries as a miss.

// File: rtl/wo_pkg.sv
package wo_pkg;

  typedef enum logic [1:0] {
    LS_INV   = 2'd0,
    LS_VALID = 2'd1,
    LS_RSVD  = 2'd2,
    LS_DIRTY = 2'd3
  } lineState_e;

  typedef enum logic [1:0] {
    BC_NONE  = 2'd0,
    BC_READ  = 2'd1,
    BC_WTHRU = 2'd2,
    BC_WBACK = 2'd3
  } busCmd_e;

  typedef enum logic [1:0] {
    SC_NONE  = 2'd0,
    SC_READ  = 2'd1,
    SC_WTHRU = 2'd2,
    SC_INVAL = 2'd3
  } snpCmd_e;

  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_WRITE = 2'd1,
    OP_EVICT = 2'd2,
    OP_RSVD  = 2'd3
  } cpuOp_e;

  // strobes from control to the state array
  typedef struct packed {
    logic       wrEn;
    lineState_e wrState;
  } ctrlStrobe_t;

  // effect of a snooped transaction on one local copy
  function automatic lineState_e snoopNext(lineState_e cur, snpCmd_e cmd);
    lineState_e nxt;
    nxt = cur;
    case (cmd)
      SC_READ:  if (cur == LS_DIRTY || cur == LS_RSVD) nxt = LS_VALID;
      SC_WTHRU,
      SC_INVAL: nxt = LS_INV;
      default:  nxt = cur;
    endcase
    return nxt;
  endfunction

endpackage

// File: rtl/wo_state_array.sv
module wo_state_array
  import wo_pkg::*;
#(
  parameter int NUM_LINES = 8,
  localparam int IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [IDX_W-1:0] cpuLine,
  input  ctrlStrobe_t      strobe,
  input  logic             snpValid,
  input  logic [1:0]       snpCmd,
  input  logic [IDX_W-1:0] snpLine,
  input  logic             snpTagHit,
  output lineState_e       cpuState,
  output logic             snpSupply,
  output logic             collide
);

  logic [NUM_LINES-1:0][1:0] stateVec;
  logic                      snpEff;
  snpCmd_e                   snpCmdE;
  lineState_e                snpState;

  assign snpEff  = snpValid && snpTagHit;
  assign snpCmdE = snpCmd_e'(snpCmd);

  for (genvar g = 0; g < NUM_LINES; g++) begin : gLine
    lineState_e stQ;
    lineState_e snpNext;
    logic       snpHere;
    logic       cpuHere;

    assign snpHere = snpEff && (snpLine == IDX_W'(g));
    assign cpuHere = strobe.wrEn && (cpuLine == IDX_W'(g));
    assign snpNext = snoopNext(stQ, snpCmdE);

    // a snoop that changes the line wins over a local update
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        stQ <= LS_INV;
      end else if (snpHere && (snpNext != stQ)) begin
        stQ <= snpNext;
      end else if (cpuHere) begin
        stQ <= strobe.wrState;
      end
    end

    assign stateVec[g] = stQ;
  end

  assign cpuState  = lineState_e'(stateVec[cpuLine]);
  assign snpState  = lineState_e'(stateVec[snpLine]);
  assign snpSupply = snpEff && (snpCmdE != SC_NONE) && (snpState == LS_DIRTY);
  assign collide   = snpEff && (snpLine == cpuLine) &&
                     (snoopNext(cpuState, snpCmdE) != cpuState);

endmodule

// File: rtl/wo_ctrl.sv
module wo_ctrl
  import wo_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cpuReq,
  input  logic [1:0]  cpuOp,
  input  logic        tagHit,
  input  lineState_e  cpuState,
  input  logic        collide,
  input  logic        busAck,
  output logic        busReq,
  output logic [1:0]  busCmd,
  output logic        cpuDone,
  output ctrlStrobe_t strobe
);

  typedef enum logic [2:0] {
    ST_IDLE, ST_RD, ST_WT, ST_WB, ST_DONE
  } ctrlState_e;

  ctrlState_e fsmQ, fsmD;
  cpuOp_e     op;
  logic       hit;

  assign op  = cpuOp_e'(cpuOp);
  assign hit = tagHit && (cpuState != LS_INV);

  always_comb begin
    fsmD   = fsmQ;
    strobe = '0;
    case (fsmQ)
      ST_IDLE: begin
        if (cpuReq && !collide) begin
          case (op)
            OP_WRITE: begin
              if (!hit)                       fsmD = ST_RD;
              else if (cpuState == LS_VALID)  fsmD = ST_WT;
              else begin
                strobe = '{wrEn: 1'b1, wrState: LS_DIRTY};
                fsmD   = ST_DONE;
              end
            end
            OP_EVICT: begin
              if (hit && cpuState == LS_DIRTY) fsmD = ST_WB;
              else begin
                strobe = '{wrEn: hit, wrState: LS_INV};
                fsmD   = ST_DONE;
              end
            end
            default: fsmD = hit ? ST_DONE : ST_RD;
          endcase
        end
      end
      ST_RD: begin
        if (collide) fsmD = ST_IDLE;
        else if (busAck) begin
          strobe = '{wrEn: 1'b1, wrState: LS_VALID};
          fsmD   = (op == OP_WRITE) ? ST_WT : ST_DONE;
        end
      end
      ST_WT: begin
        if (collide) fsmD = ST_IDLE;
        else if (busAck) begin
          strobe = '{wrEn: 1'b1, wrState: LS_RSVD};
          fsmD   = ST_DONE;
        end
      end
      ST_WB: begin
        if (collide) fsmD = ST_IDLE;
        else if (busAck) begin
          strobe = '{wrEn: 1'b1, wrState: LS_INV};
          fsmD   = ST_DONE;
        end
      end
      default: fsmD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) fsmQ <= ST_IDLE;
    else       fsmQ <= fsmD;
  end

  always_comb begin
    case (fsmQ)
      ST_RD:   busCmd = BC_READ;
      ST_WT:   busCmd = BC_WTHRU;
      ST_WB:   busCmd = BC_WBACK;
      default: busCmd = BC_NONE;
    endcase
  end

  assign busReq  = (fsmQ == ST_RD) || (fsmQ == ST_WT) || (fsmQ == ST_WB);
  assign cpuDone = (fsmQ == ST_DONE);

endmodule

// File: rtl/wo_line_ctrl.sv
module wo_line_ctrl
  import wo_pkg::*;
#(
  parameter int NUM_LINES = 8,
  localparam int IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cpuReq,
  input  logic [1:0]       cpuOp,
  input  logic [IDX_W-1:0] cpuLine,
  input  logic             tagHit,
  output logic             cpuDone,
  output logic [1:0]       lookupState,
  output logic             busReq,
  output logic [1:0]       busCmd,
  output logic [IDX_W-1:0] busLine,
  input  logic             busAck,
  input  logic             snpValid,
  input  logic [1:0]       snpCmd,
  input  logic [IDX_W-1:0] snpLine,
  input  logic             snpTagHit,
  output logic             snpSupply
);

  ctrlStrobe_t strobe;
  lineState_e  cpuState;
  logic        collide;

  wo_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .cpuReq   (cpuReq),
    .cpuOp    (cpuOp),
    .tagHit   (tagHit),
    .cpuState (cpuState),
    .collide  (collide),
    .busAck   (busAck),
    .busReq   (busReq),
    .busCmd   (busCmd),
    .cpuDone  (cpuDone),
    .strobe   (strobe)
  );

  wo_state_array #(.NUM_LINES(NUM_LINES)) u_array (
    .clk       (clk),
    .rstN      (rstN),
    .cpuLine   (cpuLine),
    .strobe    (strobe),
    .snpValid  (snpValid),
    .snpCmd    (snpCmd),
    .snpLine   (snpLine),
    .snpTagHit (snpTagHit),
    .cpuState  (cpuState),
    .snpSupply (snpSupply),
    .collide   (collide)
  );

  assign lookupState = cpuState;
  assign busLine     = cpuLine;

endmodule

// File: rtl/wo_line_ctrl_chk.sv
module wo_line_ctrl_chk #(
  parameter int NUM_LINES = 8,
  localparam int IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input logic             clk,
  input logic             rstN,
  input logic             cpuReq,
  input logic [1:0]       cpuOp,
  input logic [IDX_W-1:0] cpuLine,
  input logic             tagHit,
  input logic             cpuDone,
  input logic [1:0]       lookupState,
  input logic             busReq,
  input logic [1:0]       busCmd,
  input logic             busAck,
  input logic             snpValid,
  input logic [1:0]       snpCmd,
  input logic [IDX_W-1:0] snpLine,
  input logic             snpTagHit,
  input logic             snpSupply
);

  logic idle, snpOnLine, snpChanges;

  assign idle       = !busReq && !cpuDone;
  assign snpOnLine  = snpValid && snpTagHit && (snpCmd != 2'd0) && (snpLine == cpuLine);
  assign snpChanges = snpOnLine && (lookupState != 2'd0) &&
                      !((snpCmd == 2'd1) && (lookupState == 2'd1));

  // R2
  rd_fill_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    busReq && busCmd == 2'd1 && busAck && !snpChanges
    |=> (lookupState == 2'd1) || (cpuLine != $past(cpuLine)));

  // R3
  wt_issue_chk: assert property (@(posedge clk) disable iff (!rstN)
    idle && cpuReq && cpuOp == 2'd1 && tagHit && lookupState == 2'd1 && !snpChanges
    |=> busReq && busCmd == 2'd2);

  // R3
  wt_done_rsvd_chk: assert property (@(posedge clk) disable iff (!rstN)
    busReq && busCmd == 2'd2 && busAck && !snpChanges
    |=> (lookupState == 2'd2) || (cpuLine != $past(cpuLine)));

  // R5
  wr_local_dirty_chk: assert property (@(posedge clk) disable iff (!rstN)
    idle && cpuReq && cpuOp == 2'd1 && tagHit && lookupState[1] && !snpChanges
    |=> !busReq && cpuDone && ((lookupState == 2'd3) || (cpuLine != $past(cpuLine))));

  // R6
  snp_supply_chk: assert property (@(posedge clk) disable iff (!rstN)
    snpOnLine && lookupState == 2'd3 |-> snpSupply);

  // R6
  snp_rd_dirty_chk: assert property (@(posedge clk) disable iff (!rstN)
    snpOnLine && snpCmd == 2'd1 && lookupState == 2'd3
    |=> (lookupState == 2'd1) || (cpuLine != $past(cpuLine)));

  // R9
  evict_clean_chk: assert property (@(posedge clk) disable iff (!rstN)
    idle && cpuReq && cpuOp == 2'd2 && tagHit &&
    (lookupState == 2'd1 || lookupState == 2'd2) && !snpChanges
    |=> !busReq && cpuDone && ((lookupState == 2'd0) || (cpuLine != $past(cpuLine))));

  // R10
  snp_inval_chk: assert property (@(posedge clk) disable iff (!rstN)
    snpOnLine && snpCmd == 2'd3
    |=> (lookupState == 2'd0) || (cpuLine != $past(cpuLine)));

  // R11
  collide_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    busReq && !busAck && snpChanges |=> !busReq);

  // R12
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    cpuDone |=> !cpuDone);

endmodule

bind wo_line_ctrl wo_line_ctrl_chk #(.NUM_LINES(NUM_LINES)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .cpuReq      (cpuReq),
  .cpuOp       (cpuOp),
  .cpuLine     (cpuLine),
  .tagHit      (tagHit),
  .cpuDone     (cpuDone),
  .lookupState (lookupState),
  .busReq      (busReq),
  .busCmd      (busCmd),
  .busAck      (busAck),
  .snpValid    (snpValid),
  .snpCmd      (snpCmd),
  .snpLine     (snpLine),
  .snpTagHit   (snpTagHit),
  .snpSupply   (snpSupply)
);

// File: tb/wo_line_ctrl_bench.sv
`timescale 1ns/1ps
module wo_line_ctrl_bench;

  localparam int NL    = 8;
  localparam int IDX_W = 3;

  localparam logic [1:0] S_INV = 2'd0, S_VAL = 2'd1, S_RSV = 2'd2, S_DRT = 2'd3;
  localparam logic [1:0] OPR = 2'd0, OPW = 2'd1, OPE = 2'd2;
  localparam logic [1:0] B_RD = 2'd1, B_WT = 2'd2, B_WB = 2'd3;

  logic             clk = 1'b0;
  logic             rstN;
  logic             cpuReq   [2];
  logic [1:0]       cpuOp    [2];
  logic [IDX_W-1:0] cpuLine  [2];
  logic             tagHit   [2];
  logic             cpuDone  [2];
  logic [1:0]       lookupState [2];
  logic             busReq   [2];
  logic [1:0]       busCmd   [2];
  logic [IDX_W-1:0] busLine  [2];
  logic             busAck   [2];
  logic             snpValid [2];
  logic [1:0]       snpCmd   [2];
  logic [IDX_W-1:0] snpLine  [2];
  logic             snpSupply[2];
  logic             injInv   [2];
  logic [IDX_W-1:0] injLine;

  int checks = 0;
  int errors = 0;

  typedef struct {
    int         id;
    logic [1:0] cmd;
    int         line;
    logic       sup;
  } txn_t;
  txn_t expQ[$];

  always #10 clk = ~clk;

  // shared bus: cache 0 wins arbitration, one transaction per cycle
  assign busAck[0]   = busReq[0];
  assign busAck[1]   = busReq[1] && !busReq[0];
  assign snpValid[1] = (busAck[0] && busCmd[0] != B_WB) || injInv[1];
  assign snpCmd[1]   = injInv[1] ? 2'd3 : busCmd[0];
  assign snpLine[1]  = injInv[1] ? injLine : busLine[0];
  assign snpValid[0] = (busAck[1] && busCmd[1] != B_WB) || injInv[0];
  assign snpCmd[0]   = injInv[0] ? 2'd3 : busCmd[1];
  assign snpLine[0]  = injInv[0] ? injLine : busLine[1];

  wo_line_ctrl #(.NUM_LINES(NL)) u_wo_line_ctrl (
    .clk(clk), .rstN(rstN), .cpuReq(cpuReq[0]), .cpuOp(cpuOp[0]),
    .cpuLine(cpuLine[0]), .tagHit(tagHit[0]), .cpuDone(cpuDone[0]),
    .lookupState(lookupState[0]), .busReq(busReq[0]), .busCmd(busCmd[0]),
    .busLine(busLine[0]), .busAck(busAck[0]), .snpValid(snpValid[0]),
    .snpCmd(snpCmd[0]), .snpLine(snpLine[0]), .snpTagHit(1'b1),
    .snpSupply(snpSupply[0]));

  wo_line_ctrl #(.NUM_LINES(NL)) u_peer (
    .clk(clk), .rstN(rstN), .cpuReq(cpuReq[1]), .cpuOp(cpuOp[1]),
    .cpuLine(cpuLine[1]), .tagHit(tagHit[1]), .cpuDone(cpuDone[1]),
    .lookupState(lookupState[1]), .busReq(busReq[1]), .busCmd(busCmd[1]),
    .busLine(busLine[1]), .busAck(busAck[1]), .snpValid(snpValid[1]),
    .snpCmd(snpCmd[1]), .snpLine(snpLine[1]), .snpTagHit(1'b1),
    .snpSupply(snpSupply[1]));

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic expectBus(input int id, input logic [1:0] cmd, input int line, input logic sup);
    txn_t t;
    t.id = id; t.cmd = cmd; t.line = line; t.sup = sup;
    expQ.push_back(t);
  endtask

  // monitor: compare every acknowledged bus command with the scoreboard
  always @(negedge clk) begin
    if (rstN) begin
      for (int i = 0; i < 2; i++) begin
        if (busReq[i] && busAck[i]) begin
          checks++;
          if (expQ.size() == 0) begin
            errors++;
            $display("FAIL R2/R3/R7/R9 bus: actual cache %0d cmd %0d line %0d, expected no command",
                     i, busCmd[i], busLine[i]);
          end else begin
            txn_t t;
            t = expQ.pop_front();
            if (t.id != i || t.cmd != busCmd[i] || t.line != int'(busLine[i]) ||
                t.sup != snpSupply[1-i]) begin
              errors++;
              $display("FAIL R2/R3/R6/R7/R9 bus: actual cache %0d cmd %0d line %0d sup %0d, expected cache %0d cmd %0d line %0d sup %0d",
                       i, busCmd[i], busLine[i], snpSupply[1-i], t.id, t.cmd, t.line, t.sup);
            end
          end
        end
      end
    end
  end

  // starts and ends at a falling edge
  task automatic doOp(input int id, input logic [1:0] op, input int line, input logic th);
    cpuOp[id] = op; cpuLine[id] = IDX_W'(line); tagHit[id] = th; cpuReq[id] = 1'b1;
    do @(negedge clk); while (!cpuDone[id]);
    cpuReq[id] = 1'b0; tagHit[id] = 1'b1;
    @(negedge clk);
    check("R12 done pulse", int'(cpuDone[id]), 0);
  endtask

  task automatic chkState(input int id, input int line, input logic [1:0] exp, input string req);
    cpuLine[id] = IDX_W'(line);
    #1;
    check(req, int'(lookupState[id]), int'(exp));
  endtask

  task automatic chkQueueEmpty(input string req);
    check(req, expQ.size(), 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual run still going, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rstN = 1'b0; injLine = '0;
    for (int i = 0; i < 2; i++) begin
      cpuReq[i] = 1'b0; cpuOp[i] = OPR; cpuLine[i] = '0; tagHit[i] = 1'b1; injInv[i] = 1'b0;
    end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int l = 0; l < NL; l++) begin
      chkState(0, l, S_INV, "R1 reset c0");
      chkState(1, l, S_INV, "R1 reset c1");
    end

    // R2 read miss then read hit
    expectBus(0, B_RD, 2, 1'b0);
    doOp(0, OPR, 2, 1'b1);
    chkState(0, 2, S_VAL, "R2 fill valid");
    doOp(0, OPR, 2, 1'b1);
    chkQueueEmpty("R2 read hit no bus");
    expectBus(1, B_RD, 2, 1'b0);
    doOp(1, OPR, 2, 1'b1);
    chkState(1, 2, S_VAL, "R2 peer fill");
    chkState(0, 2, S_VAL, "R2 shared stays valid");

    // R3/R4 first write goes through
    expectBus(0, B_WT, 2, 1'b0);
    doOp(0, OPW, 2, 1'b1);
    chkState(0, 2, S_RSV, "R3 reserved");
    chkState(1, 2, S_INV, "R4 peer invalidated");

    // R5 later writes stay local
    doOp(0, OPW, 2, 1'b1);
    chkState(0, 2, S_DRT, "R5 reserved to dirty");
    doOp(0, OPW, 2, 1'b1);
    doOp(0, OPR, 2, 1'b1);
    chkState(0, 2, S_DRT, "R5 dirty stays dirty");
    chkQueueEmpty("R5 no bus");

    // R6 read by peer of a dirty line
    expectBus(1, B_RD, 2, 1'b1);
    doOp(1, OPR, 2, 1'b1);
    chkState(0, 2, S_VAL, "R6 dirty to valid");
    chkState(1, 2, S_VAL, "R6 reader valid");

    // R7 write miss
    expectBus(1, B_RD, 5, 1'b0);
    expectBus(1, B_WT, 5, 1'b0);
    doOp(1, OPW, 5, 1'b1);
    chkState(1, 5, S_RSV, "R7 write miss reserved");
    chkQueueEmpty("R7 two bus steps");

    // R8 snooped read of a reserved line
    expectBus(0, B_RD, 5, 1'b0);
    doOp(0, OPR, 5, 1'b1);
    chkState(1, 5, S_VAL, "R8 reserved to valid");

    // R7 write miss against a dirty peer copy
    expectBus(0, B_RD, 3, 1'b0);
    expectBus(0, B_WT, 3, 1'b0);
    doOp(0, OPW, 3, 1'b1);
    doOp(0, OPW, 3, 1'b1);
    chkState(0, 3, S_DRT, "R5 dirty after second write");
    expectBus(1, B_RD, 3, 1'b1);
    expectBus(1, B_WT, 3, 1'b0);
    doOp(1, OPW, 3, 1'b1);
    chkState(1, 3, S_RSV, "R7 requester reserved");
    chkState(0, 3, S_INV, "R7 other copy invalid");

    // R9 evictions
    doOp(1, OPW, 3, 1'b1);
    expectBus(1, B_WB, 3, 1'b0);
    doOp(1, OPE, 3, 1'b1);
    chkState(1, 3, S_INV, "R9 dirty evict invalid");
    doOp(0, OPE, 2, 1'b1);
    chkState(0, 2, S_INV, "R9 valid evict invalid");
    doOp(0, OPE, 2, 1'b1);
    chkQueueEmpty("R9 clean evict no bus");

    // R10 snooped invalidate of a dirty copy
    expectBus(0, B_RD, 6, 1'b0);
    expectBus(0, B_WT, 6, 1'b0);
    doOp(0, OPW, 6, 1'b1);
    doOp(0, OPW, 6, 1'b1);
    cpuLine[0] = 3'd6;
    injLine = 3'd6; injInv[0] = 1'b1;
    #1;
    check("R10 supply on invalidate", int'(snpSupply[0]), 1);
    @(negedge clk);
    injInv[0] = 1'b0;
    chkState(0, 6, S_INV, "R10 invalidated");

    // R2 tag mismatch is a miss
    expectBus(0, B_RD, 4, 1'b0);
    doOp(0, OPR, 4, 1'b1);
    expectBus(0, B_RD, 4, 1'b0);
    doOp(0, OPR, 4, 1'b0);
    chkState(0, 4, S_VAL, "R2 tag miss refilled");

    // R11 both caches write the same shared line
    expectBus(0, B_RD, 7, 1'b0);
    doOp(0, OPR, 7, 1'b1);
    expectBus(1, B_RD, 7, 1'b0);
    doOp(1, OPR, 7, 1'b1);
    expectBus(0, B_WT, 7, 1'b0);
    expectBus(1, B_RD, 7, 1'b0);
    expectBus(1, B_WT, 7, 1'b0);
    fork
      doOp(0, OPW, 7, 1'b1);
      doOp(1, OPW, 7, 1'b1);
    join
    chkState(1, 7, S_RSV, "R11 loser retried to reserved");
    chkState(0, 7, S_INV, "R11 winner invalidated");
    chkQueueEmpty("R11 withdrawn write-through not issued");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule